// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked system to an external asynchronous static RAM built from 16-bit words with one enable per byte lane. A host raises a one-cycle request carrying a direction flag, a word address, write data and a two-bit lane mask. The controller then runs one complete memory cycle on the RAM pins, with every strobe active low. It returns a one-cycle completion pulse and, for reads, the captured word.

All RAM timing is derived from picosecond parameters and the clock period. Each minimum time becomes a whole number of cycles by rounding up, with at least one cycle. A counted state machine holds each phase for that many cycles, so the pulse widths, the setup times and the bus hand-back after a read are all met by construction. After reset the controller waits out a supply settling time before it starts any access. Requests that arrive while it is not idle are dropped, so the host paces itself on the completion pulse.

Top module: `sram_ctl`

## Requirements
- R1: After reset no strobe goes low until ceil(T_PWR_PS / CLK_PS) cycles have passed, and a request raised during that wait is dropped and produces no completion pulse.
- R2: A request is taken only when the controller is idle; a request raised in any other cycle, including the last cycle of the post-read bus release, starts no access and leaves the memory unchanged.
- R3: A write drives chip enable and write enable low together with the bus driver on; mask bit 0 enables the low lane (data bits 7:0, byte enable bit 0) and mask bit 1 the high lane (bits 15:8, byte enable bit 1); a lane whose mask bit is 0 keeps its enable high and its memory byte unchanged.
- R4: Write enable stays low for at least ceil(35 ns) cycles, the write data is driven unchanged for at least ceil(25 ns) cycles before write enable rises, and the address is stable for at least ceil(35 ns) cycles before that rise.
- R5: Every write is ended by write enable rising while chip enable and the byte enables are still low and the data is still driven.
- R6: A read holds chip enable and output enable low with write enable high and the bus driver off. The word is captured no earlier than ceil(45 ns) cycles after the address is driven and no earlier than ceil(22 ns) cycles after output enable falls.
- R7: On a read a lane whose mask bit is 0 keeps its byte enable high, and that byte of the returned read data is zero.
- R8: The data bus driver is never on while output enable is low, nor in the ceil(18 ns) cycles after output enable rises.
- R9: The completion pulse is exactly one cycle wide. It comes 2 + S cycles after the request cycle, where S is the strobe length: max(ceil(22 ns), ceil(45 ns) - 1) for reads and max(ceil(35 ns), ceil(25 ns), ceil(45 ns) - 2) for writes. Read data is valid while the pulse is high.
- R10: During reset all strobes are high, the bus driver is off, the completion pulse is low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | One-cycle access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Lane mask, bit 0 = bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read word |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | DW/8 | RAM byte enables, active low |
| mem_addr | output | AW | RAM address |
| mem_dq_out | output | DW | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | DW | Data returned from the RAM |

## Verification
The bench builds the controller with a 5000 ps clock, an 8-bit address and the settling time cut to 1 µs. That gives 200 wait cycles, a read strobe of 8 cycles set by the address-to-data term rather than the output-enable term, a 7-cycle write strobe and a 4-cycle bus release. The short settling time leaves room for hundreds of mixed accesses over a small memory, so each address is written and read back many times. The smaller address width keeps the bench's RAM model at 256 words. That model returns garbage until the access times have passed and keeps driving for 18 ns after output enable rises, so a shortened phase shows up as wrong data or as contention.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the static RAM controller.
// Assumes all times are given in picoseconds as positive integers.
package sram_ctl_pkg;

    // Controller phases
    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_TURN   = 3'd5
    } ctl_state_e;

    // Whole cycles covering a time, never fewer than one
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        longint n;
        n = (longint'(t_ps) + longint'(clk_ps) - 1) / longint'(clk_ps);
        if (n < 1) n = 1;
        return int'(n);
    endfunction

    // Larger of two counts
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
// Phase down-counter plus supply settling counter.
// The phase counter is loaded on entry to a timed phase and flags its last
// cycle; the settling counter starts at N_PWR in reset and runs to zero once.
module sram_ctl_timer #(
    parameter int PH_W  = 4,
    parameter int PWR_W = 16,
    parameter int N_PWR = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PH_W-1:0] load_val,
    output logic            ph_last,
    output logic            pwr_done
);

    logic [PH_W-1:0]  ph_cnt;
    logic [PWR_W-1:0] pwr_cnt;

    // Phase counter: load, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                 ph_cnt <= '0;
        else if (load)              ph_cnt <= load_val;
        else if (ph_cnt != '0)      ph_cnt <= ph_cnt - 1'b1;
    end

    // Settling counter: runs down once after reset
    always_ff @(posedge clk) begin
        if (!rst_n)                 pwr_cnt <= PWR_W'(N_PWR);
        else if (pwr_cnt != '0)     pwr_cnt <= pwr_cnt - 1'b1;
    end

    assign ph_last  = (ph_cnt == PH_W'(1));
    assign pwr_done = (pwr_cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
// Access sequencer. Walks settle, idle, setup, strobe, hold and (after reads)
// bus release, and registers the strobes from the next state so the pins
// change exactly on phase boundaries. Assumes the timer flags ph_last in the
// final cycle of each loaded phase.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int PH_W     = 4,
    parameter int N_RD_STB = 1,
    parameter int N_WR_STB = 1,
    parameter int N_TURN   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            req_wr,
    input  logic            pwr_done,
    input  logic            ph_last,
    output logic            accept,
    output logic            load,
    output logic [PH_W-1:0] load_val,
    output logic            cap_rd,
    output logic            lanes_on_nxt,
    output logic            ce_n,
    output logic            we_n,
    output logic            oe_n,
    output logic            dq_oe,
    output logic            done
);

    ctl_state_e st_q, st_nxt;
    logic       wr_q, wr_nxt;

    // Next-state and phase-load decision
    always_comb begin
        st_nxt   = st_q;
        wr_nxt   = wr_q;
        accept   = 1'b0;
        load     = 1'b0;
        load_val = '0;
        unique case (st_q)
            ST_PWRUP:  if (pwr_done) st_nxt = ST_IDLE;
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    wr_nxt = req_wr;
                    st_nxt = ST_SETUP;
                end
            end
            ST_SETUP: begin
                st_nxt   = ST_STROBE;
                load     = 1'b1;
                load_val = wr_q ? PH_W'(N_WR_STB) : PH_W'(N_RD_STB);
            end
            ST_STROBE: if (ph_last) st_nxt = ST_HOLD;
            ST_HOLD: begin
                if (wr_q) begin
                    st_nxt = ST_IDLE;
                end else begin
                    st_nxt   = ST_TURN;
                    load     = 1'b1;
                    load_val = PH_W'(N_TURN);
                end
            end
            ST_TURN:   if (ph_last) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    assign cap_rd       = (st_q == ST_STROBE) && ph_last && !wr_q;
    assign lanes_on_nxt = (st_nxt == ST_SETUP) || (st_nxt == ST_STROBE) ||
                          (st_nxt == ST_HOLD);

    // State and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_PWRUP;
            wr_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            wr_q <= wr_nxt;
        end
    end

    // Glitch-free strobe and completion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b0;
        end else begin
            ce_n  <= !lanes_on_nxt;
            we_n  <= !((st_nxt == ST_STROBE) && wr_nxt);
            oe_n  <= !((st_nxt == ST_STROBE) && !wr_nxt);
            dq_oe <= lanes_on_nxt && wr_nxt;
            done  <= (st_nxt == ST_HOLD);
        end
    end

endmodule

// File: rtl/sram_ctl_lanes.sv
`timescale 1ns/1ps
// Address, write data and byte-lane path. Captures the request on accept,
// drives per-lane enables from the next-phase activity, and captures each
// enabled lane of the read word (disabled lanes return zero).
module sram_ctl_lanes #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    input  logic             lanes_on_nxt,
    input  logic             cap_rd,
    input  logic [DW-1:0]    mem_dq_in,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dq_out,
    output logic [LANES-1:0] mem_be_n,
    output logic [DW-1:0]    rd_data
);

    logic [LANES-1:0] mask_q, mask_nxt;

    assign mask_nxt = accept ? req_mask : mask_q;

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mask_q     <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            mask_q     <= req_mask;
        end
    end

    // Byte enables registered from the next phase
    always_ff @(posedge clk) begin
        if (!rst_n) mem_be_n <= '1;
        else        mem_be_n <= ~(mask_nxt & {LANES{lanes_on_nxt}});
    end

    // Per-lane read capture
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[8*l +: 8] <= '0;
            else if (cap_rd)
                rd_data[8*l +: 8] <= mask_q[l] ? mem_dq_in[8*l +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
// Static RAM access controller top. Turns picosecond timing parameters into
// cycle counts and connects timer, sequencer and lane path. Assumes the host
// waits for done (and the bus release after reads) before its next request.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int CLK_PS    = 5000,
    parameter int T_RC_PS   = 45000,
    parameter int T_OE_PS   = 22000,
    parameter int T_WP_PS   = 35000,
    parameter int T_DS_PS   = 25000,
    parameter int T_WC_PS   = 45000,
    parameter int T_OHZ_PS  = 18000,
    parameter int T_PWR_PS  = 200000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_mask,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DW/8-1:0]   mem_be_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DW-1:0]     mem_dq_in
);

    localparam int LANES    = DW / 8;
    localparam int N_RC     = cycles_for(T_RC_PS, CLK_PS);
    localparam int N_OE     = cycles_for(T_OE_PS, CLK_PS);
    localparam int N_WP     = cycles_for(T_WP_PS, CLK_PS);
    localparam int N_DS     = cycles_for(T_DS_PS, CLK_PS);
    localparam int N_WC     = cycles_for(T_WC_PS, CLK_PS);
    localparam int N_TURN   = cycles_for(T_OHZ_PS, CLK_PS);
    localparam int N_PWR    = cycles_for(T_PWR_PS, CLK_PS);
    localparam int N_RD_STB = max2(N_OE, N_RC - 1);
    localparam int N_WR_STB = max2(max2(N_WP, N_DS), N_WC - 2);
    localparam int PH_MAX   = max2(max2(N_RD_STB, N_WR_STB), N_TURN);
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int PWR_W    = $clog2(N_PWR + 1);

    logic            accept, load, ph_last, pwr_done, cap_rd, lanes_on_nxt;
    logic [PH_W-1:0] load_val;

    sram_ctl_timer #(
        .PH_W (PH_W),
        .PWR_W(PWR_W),
        .N_PWR(N_PWR)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .ph_last (ph_last),
        .pwr_done(pwr_done)
    );

    sram_ctl_fsm #(
        .PH_W    (PH_W),
        .N_RD_STB(N_RD_STB),
        .N_WR_STB(N_WR_STB),
        .N_TURN  (N_TURN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_wr      (req_wr),
        .pwr_done    (pwr_done),
        .ph_last     (ph_last),
        .accept      (accept),
        .load        (load),
        .load_val    (load_val),
        .cap_rd      (cap_rd),
        .lanes_on_nxt(lanes_on_nxt),
        .ce_n        (mem_ce_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .dq_oe       (mem_dq_oe),
        .done        (done)
    );

    sram_ctl_lanes #(
        .AW   (AW),
        .DW   (DW),
        .LANES(LANES)
    ) u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_mask    (req_mask),
        .lanes_on_nxt(lanes_on_nxt),
        .cap_rd      (cap_rd),
        .mem_dq_in   (mem_dq_in),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_be_n    (mem_be_n),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the RAM pins, bound into sram_ctl. Keeps its own
// cycle counters so long windows are checked without deep history.
module sram_ctl_chk #(
    parameter int N_PWR  = 1,
    parameter int N_WP   = 1,
    parameter int N_TURN = 1
) (
    input logic clk,
    input logic rst_n,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_dq_oe,
    input logic done
);

    logic [31:0] pwr_cyc, we_len, since_oe;

    // Cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                 pwr_cyc <= '0;
        else if (pwr_cyc != '1)     pwr_cyc <= pwr_cyc + 1'b1;
    end

    // Length of the current write-enable low pulse
    always_ff @(posedge clk) begin
        if (!rst_n)                 we_len <= '0;
        else if (!mem_we_n)         we_len <= we_len + 1'b1;
        else                        we_len <= '0;
    end

    // Cycles since output enable was last low, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_oe <= '1;
        else if (!mem_oe_n)         since_oe <= '0;
        else if (since_oe != '1)    since_oe <= since_oe + 1'b1;
    end

    // R1: no selection before the settling time
    assert_no_early_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> pwr_cyc >= 32'(N_PWR));

    // R3: write enable only inside a selected, driven cycle
    assert_write_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

    // R4: write pulse width
    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_len >= 32'(N_WP));

    // R5: write enable ends the write
    assert_we_ends_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    // R6: read strobes
    assert_read_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R8: no drive during or soon after output enable
    assert_bus_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && since_oe >= 32'(N_TURN)));

    // R9: single-cycle completion
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind sram_ctl sram_ctl_chk #(
    .N_PWR (N_PWR),
    .N_WP  (N_WP),
    .N_TURN(N_TURN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe),
    .done     (done)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
// Bench: RAM model with access-time and bus-release behaviour, directed
// corners, then seeded random accesses against a bench shadow memory.
module test_sram_ctl;

    localparam int AW     = 8;
    localparam int DW     = 16;
    localparam int CLK_PS = 5000;
    localparam int PWR_PS = 1000000;

    function automatic int cyc(input int t);
        int n;
        n = (t + CLK_PS - 1) / CLK_PS;
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_PWR  = PWR_PS / CLK_PS;
    localparam int B_RD   = mx(cyc(22000), cyc(45000) - 1);
    localparam int B_WR   = mx(mx(cyc(35000), cyc(25000)), cyc(45000) - 2);
    localparam int B_TURN = cyc(18000);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;
    logic [1:0]    mem_be_n;
    logic [AW-1:0] mem_addr;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_ctl #(.AW(AW), .DW(DW), .CLK_PS(CLK_PS), .T_PWR_PS(PWR_PS)) i_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .done(done), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input int a);
        return {8'(a) ^ 8'h3C, ~8'(a)};
    endfunction

    // RAM model and shadow copy
    logic [15:0] mem_m  [0:255];
    logic [15:0] exp_m  [0:255];
    int oe_cnt = 0, addr_cnt = 0, we_cnt = 0, dat_cnt = 0, rel_cnt = 100;
    logic [AW-1:0] last_addr = '0;
    logic [15:0]   last_dq = '0;
    logic          prev_we_low = 1'b0;
    logic [1:0]    prev_be = 2'b11;
    logic [AW-1:0] prev_addr = '0;
    int            prev_we_cnt = 0, prev_dat_cnt = 0, prev_addr_cnt = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = init_word(i);
            exp_m[i] = init_word(i);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // write commit when write enable rises
            if (prev_we_low && mem_we_n) begin
                chk(!mem_ce_n && mem_be_n == prev_be && mem_dq_oe, "R5 end by we",
                    {mem_ce_n, mem_be_n, mem_dq_oe}, {1'b0, prev_be, 1'b1});
                chk(prev_we_cnt >= cyc(35000), "R4 we width", prev_we_cnt, cyc(35000));
                chk(prev_dat_cnt >= cyc(25000), "R4 data setup", prev_dat_cnt, cyc(25000));
                chk(prev_addr_cnt >= cyc(35000), "R4 addr setup", prev_addr_cnt, cyc(35000));
                if (!prev_be[0]) mem_m[prev_addr][7:0]  = last_dq[7:0];
                if (!prev_be[1]) mem_m[prev_addr][15:8] = last_dq[15:8];
            end
            // bus contention against the model's late release
            if (mem_dq_oe && (!mem_oe_n || rel_cnt < B_TURN + 1))
                chk(1'b0, "R8 contention", rel_cnt, B_TURN + 1);
            if (!mem_we_n && mem_ce_n) chk(1'b0, "R3 we without ce", 1, 0);
            if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) chk(1'b0, "R6 read strobes", 1, 0);
        end
        addr_cnt = (!mem_ce_n) ? ((mem_addr == last_addr && addr_cnt > 0) ? addr_cnt + 1 : 1) : 0;
        last_addr = mem_addr;
        oe_cnt  = (!mem_oe_n) ? oe_cnt + 1 : 0;
        rel_cnt = (!mem_oe_n) ? 0 : ((rel_cnt < 100) ? rel_cnt + 1 : rel_cnt);
        dat_cnt = mem_dq_oe ? ((mem_dq_out == last_dq && dat_cnt > 0) ? dat_cnt + 1 : 1) : 0;
        last_dq = mem_dq_out;
        we_cnt  = (!mem_we_n) ? we_cnt + 1 : 0;
        prev_we_low = !mem_we_n; prev_be = mem_be_n; prev_addr = mem_addr;
        prev_we_cnt = we_cnt; prev_dat_cnt = dat_cnt; prev_addr_cnt = addr_cnt;
        // read drive: garbage until access times have passed
        for (int l = 0; l < 2; l++) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
                mem_dq_in[8*l +: 8] = (oe_cnt >= cyc(22000) && addr_cnt >= cyc(45000))
                                      ? mem_m[mem_addr][8*l +: 8] : 8'hA5;
            else if (rel_cnt <= B_TURN)
                mem_dq_in[8*l +: 8] = 8'hA5;
            else
                mem_dq_in[8*l +: 8] = 8'h5A;
        end
    end

    // One access; starts at a negedge with the controller idle
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit early_next);
        int lat;
        logic [15:0] e;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req = 1'b0;
        chk(mem_addr == a && mem_be_n == ~m && !mem_ce_n, wr ? "R3 setup lanes" : "R7 setup lanes",
            {mem_addr, mem_be_n}, {a, ~m});
        lat = 1;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        chk(lat == 2 + (wr ? B_WR : B_RD), "R9 latency", lat, 2 + (wr ? B_WR : B_RD));
        if (wr) begin
            if (m[0]) exp_m[a][7:0]  = d[7:0];
            if (m[1]) exp_m[a][15:8] = d[15:8];
        end else begin
            e = {m[1] ? exp_m[a][15:8] : 8'h00, m[0] ? exp_m[a][7:0] : 8'h00};
            chk(rd_data == e, (m == 2'b11) ? "R6 read data" : "R7 masked read", rd_data, e);
        end
        @(negedge clk);
        chk(!done, "R9 single pulse", done, 0);
        if (!wr) begin
            for (int k = 0; k < B_TURN - 1; k++) @(negedge clk);
            if (early_next) begin
                // R2: request in the last release cycle must be dropped
                req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = ~exp_m[a]; req_mask = 2'b11;
                @(negedge clk);
                req = 1'b0;
                for (int k = 0; k < 14; k++) begin
                    @(negedge clk);
                    chk(!done && mem_ce_n, "R2 dropped request", {done, mem_ce_n}, 2'b01);
                end
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        // R10 reset values
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, done} == 7'b1111100 && rd_data == 0,
            "R10 reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, done}, 7'b1111100);
        rst_n = 1'b1;
        // R1: request during settling dropped, no selection
        for (int c = 1; c <= B_PWR + 20; c++) begin
            if (c == 20) begin req = 1'b1; req_wr = 1'b1; req_addr = 8'h10; req_mask = 2'b11; end
            else req = 1'b0;
            @(negedge clk);
            if (c <= B_PWR && (!mem_ce_n || done))
                chk(1'b0, "R1 early access", {mem_ce_n, done}, 2'b10);
        end
        chk(mem_ce_n && !done, "R1 settle window", {mem_ce_n, done}, 2'b10);
        // directed lanes and masks
        access(1, 8'h10, 16'h1234, 2'b11, 0);
        access(0, 8'h10, 16'h0000, 2'b11, 0);
        access(1, 8'h10, 16'hAB77, 2'b01, 0);
        access(0, 8'h10, 16'h0000, 2'b11, 0);
        access(1, 8'h10, 16'hCD88, 2'b10, 0);
        access(0, 8'h10, 16'h0000, 2'b01, 0);
        access(0, 8'h10, 16'h0000, 2'b10, 0);
        access(1, 8'h10, 16'hFFFF, 2'b00, 0);
        access(0, 8'h10, 16'h0000, 2'b00, 0);
        access(0, 8'h10, 16'h0000, 2'b11, 1);
        access(0, 8'h10, 16'h0000, 2'b11, 0);
        access(0, 8'hFF, 16'h0000, 2'b11, 0);
        // read immediately followed by a write
        access(0, 8'h20, 16'h0000, 2'b11, 0);
        access(1, 8'h20, 16'h5AA5, 2'b11, 0);
        access(0, 8'h20, 16'h0000, 2'b11, 0);
        // seeded random mix
        void'($urandom(32'd9182));
        for (int i = 0; i < 400; i++) begin
            access(1'($urandom), 8'($urandom), 16'($urandom), 2'($urandom), 0);
            repeat ($urandom % 3) @(negedge clk);
        end
        // full sweep of model vs shadow through reads
        for (int a = 0; a < 256; a += 17) access(0, 8'(a), 16'h0, 2'b11, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule